// File: doc/BRIEF.md
# Clock Source Control Register

This block is an 8-bit control register on a simple synchronous register bus. It holds two control bits: a PLL enable, which drives `pll_on` to the PLL, and a clock source select, which drives `clk_sel` to a downstream clock multiplexer. When `clk_sel` is 1 the multiplexer takes the VCO clock, and when it is 0 it takes the crystal clock.

The two bits protect each other so that the VCO clock is never selected while the PLL is off. A write that breaks this rule is dropped without any error. A write cannot turn the PLL off while the VCO clock is selected. A write cannot select the VCO clock while the PLL is off. Every write is judged against the register contents from before that write. As a result, going from "PLL off, crystal" to "VCO selected" always takes two writes.

A stop-mode request forces the selection back to the crystal clock. The request wins over any write in the same cycle.

Top module: `clkctl_reg`

## Requirements
- R1: A synchronous active-high reset sets `pll_on` to 1 and `clk_sel` to 0.
- R2: A write happens in a cycle where `bus_sel` and `bus_wr` are both 1. On that clock edge, `bus_wdata[7]` loads the PLL enable and `bus_wdata[6]` loads the source select, subject to R3, R4 and R6. Bits 5:0 of the write data have no effect.
- R3: While `clk_sel` is 1, a write with `bus_wdata[7]`=0 leaves `pll_on` at 1. The select bit of that same write still takes effect.
- R4: While `pll_on` is 0, a write with `bus_wdata[6]`=1 leaves `clk_sel` at 0.
- R5: Both rules use the contents from before the write. Starting from `pll_on`=0 and `clk_sel`=0, a single write of 0xC0 gives `pll_on`=1 and `clk_sel`=0. A second write of 0xC0 then gives `clk_sel`=1.
- R6: When `stop_req` is 1, `clk_sel` becomes 0 on the next edge, even if a write in that cycle sets bit 6. `pll_on` follows the normal write rules in that cycle.
- R7: While `bus_sel` is 1, `bus_rdata` is a combinational function of the stored bits. Bit 7 is the PLL enable, bit 6 is the select, bits 5:4 read 0, and bits 3:0 always read 1.
- R8: While `bus_sel` is 0, `bus_rdata` is 0x00.
- R9: When `bus_wr` is 1 but `bus_sel` is 0, both stored bits keep their values.
- R10: At every clock edge after reset, `clk_sel` = 1 implies `pll_on` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Address match for this register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| stop_req | input | 1 | Stop-mode request, forces the crystal clock |
| pll_on | output | 1 | PLL enable to the PLL |
| clk_sel | output | 1 | Clock source select: 1 = VCO, 0 = crystal |

## Verification
The write path is tried with each refused pattern in turn:
- Clearing the enable while the VCO is selected shows the enable interlock works on its own.
- Setting the select while the PLL is off shows the select interlock works on its own.
- Writing 0xC0 from the all-off state, and then once more, separates checking against the old contents from checking against the new contents.
- Writing a set-select together with a stop request shows that stop wins.
- A strobe without an address match shows that the address gating works.

Read-back with all-ones write data, and read-back with the register deselected, show that the unimplemented bit fields read as fixed values whatever was written.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
    localparam int DATA_W  = 8;
    localparam int PLL_BIT = 7;
    localparam int SEL_BIT = 6;
    localparam int ONES_W  = 4;   // low bits that always read as 1

    typedef struct packed {
        logic pll;
        logic sel;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{pll: 1'b1, sel: 1'b0};
endpackage

// File: rtl/clkctl_interlock.sv
module clkctl_interlock
    import clkctl_pkg::*;
(
    input  ctl_t cur,
    input  logic wr_en,
    input  logic wr_pll,
    input  logic wr_sel,
    input  logic stop,
    output ctl_t nxt
);
    always_comb begin
        nxt = cur;
        if (wr_en) begin
            // enable may drop only when the VCO is not selected (old contents)
            nxt.pll = wr_pll | cur.sel;
            // select may rise only when the PLL was already running
            nxt.sel = wr_sel & cur.pll;
        end
        if (stop) begin
            nxt.sel = 1'b0;
        end
    end
endmodule

// File: rtl/clkctl_readback.sv
module clkctl_readback
    import clkctl_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         sel,
    input  ctl_t         cur,
    output logic [W-1:0] rdata
);
    logic [W-1:0] image;

    always_comb begin
        image = '0;
        for (int i = 0; i < ONES_W; i++) begin
            image[i] = 1'b1;
        end
        image[PLL_BIT] = cur.pll;
        image[SEL_BIT] = cur.sel;
        rdata = sel ? image : '0;
    end
endmodule

// File: rtl/clkctl_reg.sv
module clkctl_reg
    import clkctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              stop_req,
    output logic              pll_on,
    output logic              clk_sel
);
    ctl_t ctl_q;
    ctl_t ctl_d;
    ctl_t rule_out;
    logic wr_en;

    assign wr_en = bus_sel & bus_wr;

    clkctl_interlock u_lock (
        .cur    (ctl_q),
        .wr_en  (wr_en),
        .wr_pll (bus_wdata[PLL_BIT]),
        .wr_sel (bus_wdata[SEL_BIT]),
        .stop   (stop_req),
        .nxt    (rule_out)
    );

    always_comb begin
        ctl_d = rule_out;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= CTL_RESET;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    clkctl_readback #(.W(DATA_W)) u_rd (
        .sel   (bus_sel),
        .cur   (ctl_q),
        .rdata (bus_rdata)
    );

    assign pll_on  = ctl_q.pll;
    assign clk_sel = ctl_q.sel;
endmodule

// File: rtl/clkctl_reg_chk.sv
module clkctl_reg_chk (
    input logic       clk,
    input logic       rst,
    input logic       bus_sel,
    input logic       bus_wr,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic       stop_req,
    input logic       pll_on,
    input logic       clk_sel
);
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pll_on && !clk_sel));

    a_r3_keep_enable: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && clk_sel) |=> pll_on);

    a_r4_no_select_off: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && !pll_on) |=> !clk_sel);

    a_r6_stop_clears: assert property (@(posedge clk) disable iff (rst)
        stop_req |=> !clk_sel);

    a_r7_fixed_bits: assert property (@(posedge clk) disable iff (rst)
        bus_sel |-> (bus_rdata[3:0] == 4'hF && bus_rdata[5:4] == 2'b00));

    a_r8_idle_read: assert property (@(posedge clk) disable iff (rst)
        !bus_sel |-> (bus_rdata == 8'h00));

    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (!(bus_sel && bus_wr) && !stop_req) |=> ($stable(pll_on) && $stable(clk_sel)));

    a_r10_safe_pair: assert property (@(posedge clk) disable iff (rst)
        clk_sel |-> pll_on);

    logic unused_ok;
    assign unused_ok = ^bus_wdata;
endmodule

bind clkctl_reg clkctl_reg_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .stop_req  (stop_req),
    .pll_on    (pll_on),
    .clk_sel   (clk_sel)
);

// File: tb/clkctl_reg_tb.sv
module clkctl_reg_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic       bus_sel;
    logic       bus_wr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic       stop_req;
    logic       pll_on;
    logic       clk_sel;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    clkctl_reg u_dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .stop_req(stop_req),
        .pll_on(pll_on), .clk_sel(clk_sel)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic check_bits(input string req, input logic p, input logic s);
        check(req, {6'b0, pll_on, clk_sel}, {6'b0, p, s});
    endtask

    // one bus cycle, driven at a falling edge, result settled at the next falling edge
    task automatic cycle(input logic sel, input logic wr, input logic [7:0] d, input logic stop);
        @(negedge clk);
        bus_sel = sel; bus_wr = wr; bus_wdata = d; stop_req = stop;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = 8'h00; stop_req = 1'b0;
    endtask

    task automatic write(input logic [7:0] d);
        cycle(1'b1, 1'b1, d, 1'b0);
    endtask

    task automatic read_check(input string req, input logic [7:0] exp);
        bus_sel = 1'b1;
        #1;
        check(req, bus_rdata, exp);
        bus_sel = 1'b0;
        #1;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = 8'h00; stop_req = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_bits("R1", 1'b1, 1'b0);
        #1 check("R8", bus_rdata, 8'h00);
        read_check("R7", 8'h8F);
    endtask

    task automatic t_plain_write;
        write(8'h00);
        check_bits("R2", 1'b0, 1'b0);
        read_check("R7", 8'h0F);
    endtask

    task automatic t_select_refused;
        write(8'h40);
        check_bits("R4", 1'b0, 1'b0);
    endtask

    task automatic t_two_writes;
        write(8'hC0);
        check_bits("R5", 1'b1, 1'b0);
        write(8'hC0);
        check_bits("R5", 1'b1, 1'b1);
        read_check("R7", 8'hCF);
    endtask

    task automatic t_disable_refused;
        write(8'h40);
        check_bits("R3", 1'b1, 1'b1);
        write(8'h00);
        check_bits("R3", 1'b1, 1'b0);
    endtask

    task automatic t_stop;
        write(8'hC0);
        cycle(1'b1, 1'b1, 8'hC0, 1'b1);
        check_bits("R6", 1'b1, 1'b0);
        write(8'hC0);
        cycle(1'b0, 1'b0, 8'h00, 1'b1);
        check_bits("R6", 1'b1, 1'b0);
    endtask

    task automatic t_no_match;
        cycle(1'b0, 1'b1, 8'h00, 1'b0);
        check_bits("R9", 1'b1, 1'b0);
        #1 check("R8", bus_rdata, 8'h00);
    endtask

    task automatic t_ignored_bits;
        write(8'hFF);
        write(8'hFF);
        read_check("R2", 8'hCF);
        check_bits("R10", 1'b1, 1'b1);
    endtask

    initial begin
        t_reset();
        t_plain_write();
        t_select_refused();
        t_two_writes();
        t_disable_refused();
        t_stop();
        t_no_match();
        t_ignored_bits();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule